// File: doc/BRIEF.md
# 16-bit Logic, Rotate and Multiply Execution Unit

This unit is the datapath behind the word-wide register-pair operations of an 8-bit processor core. Given two operand words, an operation code and the current flag byte, it returns a result word, a second (upper) result word used only by the multiply, and the updated flag byte. It covers bitwise AND and OR, a boolean normalize that reduces any nonzero word to one, one-bit rotates left and right through the carry, and a signed multiply whose 32-bit product is split into a low and a high word.

The datapath is purely combinational: decode, register storage and memory traffic belong to the surrounding core. A single registered strobe, `done`, rises one clock after `go` so that a sequencer can treat the unit as a one-cycle step.

Flag byte layout (fixed, because the core decodes it): sign in bit 7, zero in bit 6, parity in bit 2, carry in bit 0. Bits 5, 4, 3 and 1 are never touched by the unit.

Top module: `lrmu_top`

## Requirements
- R1: Operation code 0 gives `res_lo` = `opa` AND `opb`, with sign, zero and parity from that result and carry cleared.
- R2: Operation code 1 gives `res_lo` = `opa` OR `opb`, with sign, zero and parity from that result and carry cleared.
- R3: For codes 0 to 4, flag bits 7, 6, 2 and 0 are first cleared and then set only as the operation dictates; bits 5, 4, 3 and 1 of `flags_out` always equal those of `flags_in`.
- R4: For codes 0, 1, 3 and 4, flag bit 7 equals bit 15 of `res_lo`, and flag bit 6 is set exactly when `res_lo` is zero.
- R5: For codes 0, 1, 3 and 4, flag bit 2 is set exactly when `res_lo` holds an even number of one bits (zero ones counts as even).
- R6: Code 2 (boolean normalize) gives `res_lo` = 0x0001 for any nonzero `opa` and 0x0000 for zero; flag bit 6 is set only when `opa` was zero, and bits 7, 2 and 0 are cleared.
- R7: Code 3 (rotate left through carry) gives `res_lo` = {`opa`[14:0], `flags_in`[0]} and flag bit 0 = `opa`[15].
- R8: Code 4 (rotate right through carry) gives `res_lo` = {`flags_in`[0], `opa`[15:1]} and flag bit 0 = `opa`[0].
- R9: Code 5 multiplies `opa` and `opb` as two's-complement numbers; `res_lo` is bits 15:0 and `res_hi` bits 31:16 of the product.
- R10: Code 5 leaves the flag byte unchanged: `flags_out` = `flags_in`.
- R11: Codes 6 and 7 pass `opa` to `res_lo` and leave `flags_out` = `flags_in`.
- R12: For every code other than 5, `res_hi` is 0x0000.
- R13: `done` is low during and after reset and is high in exactly the cycle after a cycle in which `go` was sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe for the current operation |
| op | input | 3 | Operation code (0 AND, 1 OR, 2 normalize, 3 rotate left, 4 rotate right, 5 multiply) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| flags_in | input | 8 | Current flag byte, carry in bit 0 |
| res_lo | output | 16 | Result word, low half of product for multiply |
| res_hi | output | 16 | High half of product, zero otherwise |
| flags_out | output | 8 | Updated flag byte |
| done | output | 1 | Registered strobe one cycle after `go` |

## Verification
Logic operations are tried with results that are zero, all ones, negative and with odd and even bit counts, so that sign, zero and parity are each seen both set and clear, and with a flag byte whose untouched bits are all ones so that clearing and preservation are told apart. Rotates are driven with the carry-in both set and clear and with the outgoing edge bit both set and clear, separating the carry-out from the carry-in. Multiply uses negative-by-positive, the most negative value squared and the largest positive value squared, which expose any unsigned treatment or swapped halves, plus a nonzero flag byte that must survive. Unused codes are driven with a zero operand to show that they do not set the zero flag.

// File: rtl/lrmu_pkg.sv
package lrmu_pkg;

    localparam int FLAG_W = 8;

    // Flag bit positions (decoded by the core, so fixed)
    localparam int FB_SIGN   = 7;
    localparam int FB_ZERO   = 6;
    localparam int FB_PARITY = 2;
    localparam int FB_CARRY  = 0;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_BOOL = 3'd2,
        OP_RL   = 3'd3,
        OP_RR   = 3'd4,
        OP_MUL  = 3'd5
    } lrmu_op_e;

    typedef enum logic [1:0] {
        FM_KEEP,     // flag byte passes through
        FM_BOOL,     // only zero flag may be set
        FM_LOGIC,    // sign, zero, parity from result, carry clear
        FM_SHIFT     // sign, zero, parity from result, carry from shifter
    } flag_mode_e;

    function automatic logic [FLAG_W-1:0] arith_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        m[FB_SIGN]   = 1'b1;
        m[FB_ZERO]   = 1'b1;
        m[FB_PARITY] = 1'b1;
        m[FB_CARRY]  = 1'b1;
        return m;
    endfunction

    function automatic flag_mode_e mode_of(input logic [2:0] code);
        case (code)
            OP_AND, OP_OR: return FM_LOGIC;
            OP_BOOL:       return FM_BOOL;
            OP_RL, OP_RR:  return FM_SHIFT;
            default:       return FM_KEEP;
        endcase
    endfunction

endpackage

// File: rtl/lrmu_parity.sv
module lrmu_parity #(
    parameter int W = 16
) (
    input  logic [W-1:0] word,
    output logic         even
);
    localparam int LV = $clog2(W);
    localparam int CW = LV + 1;

    logic [CW-1:0] cnt [0:LV][0:W-1];

    for (genvar i = 0; i < W; i++) begin : g_leaf
        assign cnt[0][i] = CW'(word[i]);
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_node
            if (i < (W >> (l + 1))) begin : g_add
                assign cnt[l+1][i] = cnt[l][2*i] + cnt[l][2*i+1];
            end else begin : g_pad
                assign cnt[l+1][i] = '0;
            end
        end
    end

    assign even = ~cnt[LV][0][0];

endmodule

// File: rtl/lrmu_logic.sv
module lrmu_logic #(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    import lrmu_pkg::*;

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_BOOL: y = (a != '0) ? W'(1) : '0;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/lrmu_rotate.sv
module lrmu_rotate #(
    parameter int W = 16
) (
    input  logic         left,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] y,
    output logic         cout
);
    always_comb begin
        if (left) begin
            y    = {a[W-2:0], cin};
            cout = a[W-1];
        end else begin
            y    = {cin, a[W-1:1]};
            cout = a[0];
        end
    end

endmodule

// File: rtl/lrmu_mul.sv
module lrmu_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod;

    assign prod = PW'($signed(a)) * PW'($signed(b));
    assign lo   = prod[W-1:0];
    assign hi   = prod[PW-1:W];

endmodule

// File: rtl/lrmu_top.sv
module lrmu_top #(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go,
    input  logic [2:0]                op,
    input  logic [W-1:0]              opa,
    input  logic [W-1:0]              opb,
    input  logic [lrmu_pkg::FLAG_W-1:0] flags_in,
    output logic [W-1:0]              res_lo,
    output logic [W-1:0]              res_hi,
    output logic [lrmu_pkg::FLAG_W-1:0] flags_out,
    output logic                      done
);
    import lrmu_pkg::*;

    localparam logic [FLAG_W-1:0] CLR = arith_mask();

    logic [W-1:0] logic_y, rot_y, mul_lo, mul_hi, sel_y;
    logic         rot_c, par_even;
    flag_mode_e   fmode;

    lrmu_logic #(.W(W)) u_logic (
        .op(op), .a(opa), .b(opb), .y(logic_y)
    );

    lrmu_rotate #(.W(W)) u_rot (
        .left(op == OP_RL), .a(opa), .cin(flags_in[FB_CARRY]),
        .y(rot_y), .cout(rot_c)
    );

    lrmu_mul #(.W(W)) u_mul (
        .a(opa), .b(opb), .lo(mul_lo), .hi(mul_hi)
    );

    lrmu_parity #(.W(W)) u_par (
        .word(sel_y), .even(par_even)
    );

    assign fmode = mode_of(op);

    always_comb begin
        case (op)
            OP_RL, OP_RR: sel_y = rot_y;
            OP_MUL:       sel_y = mul_lo;
            default:      sel_y = logic_y;
        endcase
    end

    assign res_lo = sel_y;
    assign res_hi = (op == OP_MUL) ? mul_hi : '0;

    always_comb begin
        flags_out = flags_in;
        if (fmode != FM_KEEP) begin
            flags_out = flags_in & ~CLR;
            flags_out[FB_ZERO] = (sel_y == '0);
            if (fmode != FM_BOOL) begin
                flags_out[FB_SIGN]   = sel_y[W-1];
                flags_out[FB_PARITY] = par_even;
            end
            if (fmode == FM_SHIFT)
                flags_out[FB_CARRY] = rot_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= go;
    end

    // Parity tree agrees with a reduction over the selected word
    assert_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (fmode == FM_LOGIC || fmode == FM_SHIFT) |-> ((^res_lo) != flags_out[FB_PARITY]));

    assert_bool_range_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BOOL) |-> (res_lo[W-1:1] == '0 && !flags_out[FB_SIGN]
                             && !flags_out[FB_PARITY] && !flags_out[FB_CARRY]));

    assert_rl_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RL) |-> (flags_out[FB_CARRY] == opa[W-1]));

    assert_rr_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RR) |-> (flags_out[FB_CARRY] == opa[0]));

    assert_mul_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MUL) |-> (flags_out == flags_in));

    assert_keep_bits_R3: assert property (@(posedge clk) disable iff (rst)
        ((flags_out & ~CLR) == (flags_in & ~CLR)));

    assert_hi_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (op != OP_MUL) |-> (res_hi == '0));

    assert_done_rise_R13: assert property (@(posedge clk) disable iff (rst)
        go |=> done);

    assert_done_fall_R13: assert property (@(posedge clk) disable iff (rst)
        !go |=> !done);

endmodule

// File: tb/lrmu_top_tb_top.sv
module lrmu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        go;
    logic [2:0]  op;
    logic [15:0] opa, opb, res_lo, res_hi;
    logic [7:0]  flags_in, flags_out;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lrmu_top dut_i (
        .clk(clk), .rst(rst), .go(go), .op(op), .opa(opa), .opb(opb),
        .flags_in(flags_in), .res_lo(res_lo), .res_hi(res_hi),
        .flags_out(flags_out), .done(done)
    );

    // {op, a, b, flags_in, exp_lo, exp_hi, exp_flags}
    localparam int NV = 18;
    localparam logic [82:0] VEC [NV] = '{
        {3'd0, 16'hF0F0, 16'h0FF0, 8'h00, 16'h00F0, 16'h0000, 8'h04}, // R1 R5 even
        {3'd0, 16'h1234, 16'h0000, 8'hFF, 16'h0000, 16'h0000, 8'h7E}, // R1 R3 R4 zero
        {3'd0, 16'hFFFF, 16'hFFFF, 8'h00, 16'hFFFF, 16'h0000, 8'h84}, // R1 R4 sign
        {3'd0, 16'hFFFF, 16'h0001, 8'h00, 16'h0001, 16'h0000, 8'h00}, // R1 R5 odd
        {3'd1, 16'h8000, 16'h0001, 8'h00, 16'h8001, 16'h0000, 8'h84}, // R2
        {3'd1, 16'h0007, 16'h0000, 8'hC5, 16'h0007, 16'h0000, 8'h00}, // R2 R3
        {3'd2, 16'h8000, 16'h0000, 8'hFF, 16'h0001, 16'h0000, 8'h3A}, // R6 nonzero
        {3'd2, 16'h0000, 16'h1111, 8'h00, 16'h0000, 16'h0000, 8'h40}, // R6 zero
        {3'd3, 16'h8001, 16'h0000, 8'h00, 16'h0002, 16'h0000, 8'h01}, // R7
        {3'd3, 16'h4000, 16'h0000, 8'h01, 16'h8001, 16'h0000, 8'h84}, // R7
        {3'd3, 16'h0000, 16'h0000, 8'h01, 16'h0001, 16'h0000, 8'h00}, // R7
        {3'd4, 16'h0001, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h45}, // R8
        {3'd4, 16'h0002, 16'h0000, 8'h01, 16'h8001, 16'h0000, 8'h84}, // R8
        {3'd5, 16'hFFFF, 16'h0002, 8'h5A, 16'hFFFE, 16'hFFFF, 8'h5A}, // R9 R10
        {3'd5, 16'h8000, 16'h8000, 8'h00, 16'h0000, 16'h4000, 8'h00}, // R9
        {3'd5, 16'h7FFF, 16'h7FFF, 8'h81, 16'h0001, 16'h3FFF, 8'h81}, // R9 R10
        {3'd6, 16'hABCD, 16'h1234, 8'hA5, 16'hABCD, 16'h0000, 8'hA5}, // R11
        {3'd7, 16'h0000, 16'hFFFF, 8'h00, 16'h0000, 16'h0000, 8'h00}  // R11
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R11";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R13 watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; go = 1'b0; op = 3'd0; opa = '0; opb = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        check("R13", "done in reset", 32'(done), 32'd0);
        go = 1'b1;
        @(negedge clk);
        check("R13", "go ignored in reset", 32'(done), 32'd0);
        go = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R13", "done after reset", 32'(done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [82:0] v;
            v = VEC[i];
            op = v[82:80]; opa = v[79:64]; opb = v[63:48]; flags_in = v[47:40];
            #1;
            check(req_of(op), "res_lo", 32'(res_lo), 32'(v[39:24]));
            check((op == 3'd5) ? "R9" : "R12", "res_hi", 32'(res_hi), 32'(v[23:8]));
            check((op == 3'd5) ? "R10" : ((op > 3'd5) ? "R11" : "R3 R4 R5"),
                  "flags", 32'(flags_out), 32'(v[7:0]));
            @(negedge clk);
        end

        // R3: untouched flag bits all ones survive a rotate
        op = 3'd4; opa = 16'h0000; flags_in = 8'h3A;
        #1;
        check("R3", "kept bits rotate", 32'(flags_out), 32'h7E);
        @(negedge clk);

        // R13: single go pulse gives a single done cycle
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R13", "done after go", 32'(done), 32'd1);
        @(negedge clk);
        check("R13", "done drops", 32'(done), 32'd0);

        // R13: back-to-back go then reset
        go = 1'b1;
        @(negedge clk);
        check("R13", "done held with go", 32'(done), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R13", "reset clears done", 32'(done), 32'd0);
        rst = 1'b0; go = 1'b0;
        @(negedge clk);
        check("R13", "idle after reset", 32'(done), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule